// File: doc/BRIEF.md
# Write Clock and Write-Pulse Precompensation Unit

This block sits on the write side of a floppy disk controller and runs entirely from one 16 MHz reference clock. A five-bit synchronous counter divides the reference down. From it the block produces a 500 kHz write clock. That clock is a narrow pulse, high for 250 ns in every 2 µs, and the controller uses it to pace its MFM write data.

Each write-data pulse from the controller is re-timed onto the drive's write-data line at one of three positions spaced 250 ns (four reference cycles) apart: early, nominal or late. The position is chosen by an early/late code that is sampled at the pulse's rising edge. Every emitted pulse lasts exactly four reference cycles. Each pulse travels through a tapped delay line together with its own sampled position, so a later pulse or a change on the mode inputs cannot disturb one that is already in flight. The code with both mode inputs high is illegal: it is treated as nominal and reported with a single-cycle error flag.

Top module: `wclk_precomp`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `wclk`, `wd_out` and `mode_err` are 0. Reset clears the counter, the delay line and the edge detector.
- R2: Counting clock edges after reset is released as k = 1, 2, …, `wclk` is 1 after edge k exactly when (k mod 32) < 4. It is therefore high for 4 of every 32 cycles.
- R3: A rising edge of `wd_in` with `early`=1 and `late`=0, seen at edge E0, drives `wd_out` high after edges E0 to E3 and low after E4.
- R4: With `early`=0 and `late`=0 at the rising edge (nominal), `wd_out` is high after edges E4 to E7 and low in the cycles around that span.
- R5: With `early`=0 and `late`=1 at the rising edge (late), `wd_out` is high after edges E8 to E11.
- R6: With `early`=1 and `late`=1 at the rising edge, the pulse is placed as nominal (R4), and `mode_err` is 1 for exactly the one cycle after E0.
- R7: The emitted pulse is 4 cycles wide whether `wd_in` stays high for 1 cycle or for many.
- R8: The mode inputs are used only at the rising edge of `wd_in`. A change on them afterwards does not move a pulse that is already in flight.
- R9: A second rising edge that arrives while an earlier pulse is still in the delay line is emitted at its own position with its own mode, and neither pulse is lost.
- R10: Holding `wd_in` high produces a single pulse; a new pulse needs a new 0-to-1 transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_in | input | 1 | Write-data pulse from the controller, synchronous to `clk` |
| early | input | 1 | Mode bit: request early placement |
| late | input | 1 | Mode bit: request late placement |
| wclk | output | 1 | 500 kHz write clock, 1/8 duty |
| wd_out | output | 1 | Re-timed write-data pulse to the drive |
| mode_err | output | 1 | One-cycle flag: illegal early/late code sampled |

## Verification
The two functions that can meet in one cycle are the sampling of a new pulse's mode and the emission of an older pulse that is still in the delay line. The bench provokes this in two steps. It launches a nominal pulse and flips the mode inputs to early on the very next cycle. While the first pulse still occupies the line, it then launches a second pulse under the new code. The bench judges the result cycle by cycle on `wd_out`: the first pulse must still appear at the nominal position, and the second must appear at the early position relative to its own edge.

// File: rtl/wclk_precomp_pkg.sv
package wclk_precomp_pkg;

  typedef enum logic [1:0] {
    PC_NOMINAL = 2'd0,
    PC_EARLY   = 2'd1,
    PC_LATE    = 2'd2
  } pc_mode_e;

  typedef struct packed {
    logic     valid;
    pc_mode_e mode;
  } line_slot_t;

  // early/late pair -> placement; the illegal pair (1,1) falls back to nominal
  function automatic pc_mode_e decode_mode(input logic e, input logic l);
    case ({e, l})
      2'b10:   return PC_EARLY;
      2'b01:   return PC_LATE;
      default: return PC_NOMINAL;
    endcase
  endfunction

  function automatic logic is_illegal(input logic e, input logic l);
    return e & l;
  endfunction

  // first delay-line stage on which a slot of this mode drives the output
  function automatic int unsigned tap_of(input pc_mode_e m, input int unsigned shift);
    case (m)
      PC_EARLY: return 0;
      PC_LATE:  return 2 * shift;
      default:  return shift;
    endcase
  endfunction

  // true when stage idx lies in the emission window of a slot of mode m
  function automatic logic in_window(input int unsigned idx, input pc_mode_e m,
                                     input int unsigned shift, input int unsigned width);
    int unsigned t;
    t = tap_of(m, shift);
    return (idx >= t) && (idx < t + width);
  endfunction

  // write clock is high during the first `high` states of each counter period
  function automatic logic wclk_level(input int unsigned state, input int unsigned high);
    return state < high;
  endfunction

endpackage

// File: rtl/wcp_timebase.sv
module wcp_timebase #(
  parameter int unsigned DIV_BITS  = 5,
  parameter int unsigned WCLK_HIGH = 4
) (
  input  logic                clk,
  input  logic                rst,
  output logic                wclk,
  output logic                tap_mid,
  output logic                tap_top,
  output logic [DIV_BITS-1:0] div_cnt
);
  import wclk_precomp_pkg::*;

  localparam int unsigned PERIOD = 1 << DIV_BITS;

  logic [DIV_BITS-1:0] cnt_q;
  logic [DIV_BITS-1:0] cnt_nxt;
  logic                wclk_q;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      wclk_q <= wclk_level(int'(cnt_nxt), WCLK_HIGH);
    end
  end

  // intermediate taps of the divider (1 MHz and 500 kHz at the default sizes)
  assign tap_mid = cnt_q[DIV_BITS-2];
  assign tap_top = cnt_q[DIV_BITS-1];
  assign wclk    = wclk_q;
  assign div_cnt = cnt_q;

  // R2: once the counter wraps, the write clock must be high
  a_r2_wclk_after_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == DIV_BITS'(PERIOD - 1)) |=> wclk);

  // R2: the write clock is never high in the upper half of the period
  a_r2_wclk_low_upper: assert property (@(posedge clk) disable iff (rst)
    tap_top |-> !wclk);

endmodule

// File: rtl/wcp_edge_sampler.sv
module wcp_edge_sampler (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wd_in,
  input  logic                       early,
  input  logic                       late,
  output logic                       start,
  output wclk_precomp_pkg::pc_mode_e start_mode,
  output logic                       mode_err
);
  import wclk_precomp_pkg::*;

  logic wd_prev_q;
  logic err_q;

  // R10: only a 0-to-1 transition launches a pulse
  assign start      = wd_in & ~wd_prev_q;
  assign start_mode = decode_mode(early, late);

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_prev_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      wd_prev_q <= wd_in;
      err_q     <= start & is_illegal(early, late);
    end
  end

  assign mode_err = err_q;

  // R6: the error flag lasts a single cycle
  a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
    mode_err |=> !mode_err);

  // R6: the flag needs a rising write pulse under the illegal code
  a_r6_err_source: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> $past(wd_in && early && late));

endmodule

// File: rtl/wcp_delay_line.sv
module wcp_delay_line #(
  parameter int unsigned SHIFT_CYC = 4,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  wclk_precomp_pkg::pc_mode_e push_mode,
  output logic                       wd_out,
  output logic                       busy
);
  import wclk_precomp_pkg::*;

  localparam int unsigned DEPTH = 2 * SHIFT_CYC + PULSE_CYC;

  line_slot_t             line_q [DEPTH];
  logic       [DEPTH-1:0] hit;
  logic       [DEPTH-1:0] occ;

  // stage 0 takes the new pulse; each stage carries its own mode (R8, R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q[0] <= '{valid: 1'b0, mode: PC_NOMINAL};
    end else begin
      line_q[0] <= '{valid: push, mode: push_mode};
    end
  end

  for (genvar j = 1; j < DEPTH; j++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[j] <= '{valid: 1'b0, mode: PC_NOMINAL};
      end else begin
        line_q[j] <= line_q[j-1];
      end
    end
  end

  // a stage drives the output while it lies inside its slot's window (R3-R5, R7)
  for (genvar j = 0; j < DEPTH; j++) begin : g_tap
    assign occ[j] = line_q[j].valid;
    assign hit[j] = line_q[j].valid &&
                    in_window(j, line_q[j].mode, SHIFT_CYC, PULSE_CYC);
  end

  assign wd_out = |hit;
  assign busy   = |occ;

  // R1: an empty line drives nothing
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wd_out);

  // R7: an emitted pulse never lasts a single cycle
  a_r7_min_width: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_out) |=> wd_out);

endmodule

// File: rtl/wclk_precomp.sv
module wclk_precomp #(
  parameter int unsigned DIV_BITS  = 5,
  parameter int unsigned WCLK_HIGH = 4,
  parameter int unsigned SHIFT_CYC = 4,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wd_in,
  input  logic early,
  input  logic late,
  output logic wclk,
  output logic wd_out,
  output logic mode_err
);
  import wclk_precomp_pkg::*;

  logic                start;
  pc_mode_e            start_mode;
  logic                tap_mid;
  logic                tap_top;
  logic [DIV_BITS-1:0] div_cnt;
  logic                line_busy;

  wcp_timebase #(
    .DIV_BITS (DIV_BITS),
    .WCLK_HIGH(WCLK_HIGH)
  ) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .wclk   (wclk),
    .tap_mid(tap_mid),
    .tap_top(tap_top),
    .div_cnt(div_cnt)
  );

  wcp_edge_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .wd_in     (wd_in),
    .early     (early),
    .late      (late),
    .start     (start),
    .start_mode(start_mode),
    .mode_err  (mode_err)
  );

  wcp_delay_line #(
    .SHIFT_CYC(SHIFT_CYC),
    .PULSE_CYC(PULSE_CYC)
  ) u_line (
    .clk      (clk),
    .rst      (rst),
    .push     (start),
    .push_mode(start_mode),
    .wd_out   (wd_out),
    .busy     (line_busy)
  );

  // R3: an early launch shows on the output right after its edge
  a_r3_early_immediate: assert property (@(posedge clk) disable iff (rst)
    (start && start_mode == PC_EARLY) |=> wd_out);

  // R4/R5: nominal and late launches stay quiet on the next cycle unless older pulses are in flight
  a_r4_nominal_waits: assert property (@(posedge clk) disable iff (rst)
    (start && start_mode != PC_EARLY && !line_busy) |=> !wd_out);

  // R2: the middle tap is low whenever the write clock is high
  a_r2_mid_tap_low: assert property (@(posedge clk) disable iff (rst)
    wclk |-> (!tap_mid && !tap_top));

  // R1: right after reset every output is low
  a_r1_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> (!wclk && !wd_out && !mode_err));

endmodule

// File: tb/wclk_precomp_bench.sv
module wclk_precomp_bench;

  localparam int CLK_PERIOD = 62;
  localparam int STEP       = 4;
  localparam int WIDTH      = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wd_in = 1'b0;
  logic early = 1'b0;
  logic late = 1'b0;
  logic wclk, wd_out, mode_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wclk_precomp u_wclk_precomp (
    .clk     (clk),
    .rst     (rst),
    .wd_in   (wd_in),
    .early   (early),
    .late    (late),
    .wclk    (wclk),
    .wd_out  (wd_out),
    .mode_err(mode_err)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // placement offset in cycles after the sampling edge, restated from R3-R6
  function automatic int offset_for(input logic e, input logic l);
    if (e && !l) return 0;
    if (l && !e) return 2 * STEP;
    return STEP;
  endfunction

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1", "wclk in reset", wclk, 1'b0);
      check("R1", "wd_out in reset", wd_out, 1'b0);
      check("R1", "mode_err in reset", mode_err, 1'b0);
    end
    rst = 1'b0;
  endtask

  // R2: starts right after reset release
  task automatic test_wclk();
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      check("R2", $sformatf("wclk after edge %0d", k), wclk, logic'((k % 32) < 4));
    end
  endtask

  // one pulse; mode inputs changed to (ce,cl) right after the sampling edge
  task automatic one_pulse(input string req, input logic e, input logic l,
                           input int width, input logic ce, input logic cl);
    int off;
    off = offset_for(e, l);
    @(negedge clk);
    wd_in = 1'b1;
    early = e;
    late  = l;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check(req, $sformatf("wd_out after E%0d", k), wd_out,
            logic'(k >= off && k < off + WIDTH));
      check(req, $sformatf("mode_err after E%0d", k), mode_err, logic'(k == 0 && e && l));
      if (k == 0) begin
        early = ce;
        late  = cl;
      end
      if (k + 1 == width) wd_in = 1'b0;
    end
    wd_in = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(req, "wd_out quiet after pulse", wd_out, 1'b0);
    end
  endtask

  // R8 + R9: nominal pulse, mode flipped to early, second pulse launched while first in line
  task automatic two_pulses();
    @(negedge clk);
    wd_in = 1'b1;
    early = 1'b0;
    late  = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R9", $sformatf("overlap wd_out after E%0d", k), wd_out,
            logic'((k >= 4 && k < 8) || (k >= 10 && k < 14)));
      check("R8", $sformatf("overlap mode_err after E%0d", k), mode_err, 1'b0);
      if (k == 0) early = 1'b1;
      if (k == 1) wd_in = 1'b0;
      if (k == 9) wd_in = 1'b1;
      if (k == 11) wd_in = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_wclk();
    one_pulse("R3", 1'b1, 1'b0, 1,  1'b1, 1'b0);
    one_pulse("R4", 1'b0, 1'b0, 2,  1'b0, 1'b0);
    one_pulse("R5", 1'b0, 1'b1, 3,  1'b0, 1'b1);
    one_pulse("R6", 1'b1, 1'b1, 2,  1'b0, 1'b0);
    one_pulse("R7", 1'b1, 1'b0, 12, 1'b1, 1'b0);
    one_pulse("R8", 1'b0, 1'b1, 2,  1'b1, 1'b0);
    one_pulse("R10", 1'b0, 1'b0, 40, 1'b0, 1'b0);
    two_pulses();
    test_reset();
    test_wclk();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule